// File: doc/BRIEF.md
# Level-Trigger Remote IRR and End-of-Interrupt Tracker

This block keeps the per-pin delivery state of an interrupt redirection unit with 24 inputs. Each pin has a small configuration entry (vector, trigger kind, mask). The block also holds two status bits per entry. The first is a delivery-status bit, raised by a request pulse on the pin, meaning "waiting to be sent". The second is a remote-IRR bit, meaning "a level interrupt is in service and has not yet been acknowledged".

The block picks one eligible pin at a time and offers it on a valid/ready delivery port. The offer carries the pin index, vector and trigger kind. When the handshake completes, the block updates that pin's status bits. An end-of-interrupt input carries a vector. It releases every level-triggered entry programmed with that vector in a single cycle, and then those entries may be delivered again. Building the message and carrying out the bus transfer are left to the logic downstream.

Top module: `irq_eoi_tracker`

## Requirements
- R1: After a synchronous reset, every entry is masked, edge-triggered, with vector 0. All remote-IRR and delivery-status bits read 0, and `dlv_valid` is 0.
- R2: A pulse on `irq_pulse[i]` sets delivery status of entry i on the next edge. A completed handshake for pin i clears it, unless a new pulse for i arrives in that same cycle.
- R3: An entry whose mask bit is 1 is never offered. Its delivery status stays 1, and it is offered after the mask is cleared.
- R4: When several entries are eligible, the lowest-numbered one is offered first. The others stay pending and follow in ascending order.
- R5: An offer stays on the port with pin, vector and trigger kind unchanged for as long as `dlv_ready` is low.
- R6: A completed handshake for a level entry (`cfg_level`=1) sets its remote-IRR bit. A handshake for an edge entry leaves it unchanged.
- R7: A level entry whose remote-IRR bit is 1 is not offered, even with delivery status 1, until that bit is cleared.
- R8: An end-of-interrupt with vector V clears remote IRR on every entry that is level-triggered with vector V. Entries that are edge-triggered or that hold another vector keep their bit.
- R9: When an end-of-interrupt and a handshake hit the same level entry in one cycle, the clear is applied first and the set second, so the bit ends at 1.
- R10: A write with `cfg_we`=1 loads vector, trigger kind and mask into entry `cfg_idx` on the next edge. The status bits are not touched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_pulse | input | 24 | One-cycle service request per pin |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 5 | Entry index for the write |
| cfg_vec | input | 8 | Vector to store |
| cfg_level | input | 1 | 1 = level-triggered, 0 = edge-triggered |
| cfg_mask | input | 1 | 1 = masked |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vec | input | 8 | Vector carried by the end-of-interrupt |
| dlv_valid | output | 1 | Delivery offer present |
| dlv_ready | input | 1 | Downstream accepts the offer |
| dlv_pin | output | 5 | Pin of the offer |
| dlv_vec | output | 8 | Vector of the offer |
| dlv_level | output | 1 | Trigger kind of the offer |
| rirr_o | output | 24 | Remote-IRR bit per entry |
| dstat_o | output | 24 | Delivery-status bit per entry |

## Verification
The bench goes after four corner cases, each with the failure it would expose:
- **Same-cycle end-of-interrupt and handshake on one entry.** A design that applies the two updates in the wrong order would leave the bit at 0 and allow a second, premature delivery.
- **End-of-interrupt on an entry switched from level to edge while its remote-IRR bit was still 1.** A design that matches on vector alone would wrongly clear it.
- **Re-requesting a level pin that is still in service.** A design that ignores remote IRR would send it twice.
- **Three simultaneous requests under back-pressure.** These expose a wrong priority order and an offer that changes while `dlv_ready` is low.

// File: rtl/irq_track_pkg.sv
package irq_track_pkg;
  localparam int VEC_W = 8;

  typedef struct packed {
    logic [VEC_W-1:0] vec;
    logic             level;
    logic             mask;
  } pin_cfg_t;
endpackage

// File: rtl/lowest_first_pick.sv
module lowest_first_pick #(
  parameter int N  = 24,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  elig,
  output logic          found,
  output logic [IW-1:0] idx,
  output logic [N-1:0]  grant
);
  logic [N:0] seen;
  assign seen[0] = 1'b0;

  for (genvar g = 0; g < N; g++) begin : g_chain
    assign grant[g]  = elig[g] & ~seen[g];
    assign seen[g+1] = seen[g] | elig[g];
  end

  assign found = seen[N];

  always_comb begin
    idx = '0;
    for (int k = 0; k < N; k++) begin
      if (grant[k]) idx = idx | IW'(k);
    end
  end
endmodule

// File: rtl/eoi_vector_match.sv
module eoi_vector_match
  import irq_track_pkg::*;
#(
  parameter int N = 24
) (
  input  logic             eoi_valid,
  input  logic [VEC_W-1:0] eoi_vec,
  input  pin_cfg_t         cfg [N],
  output logic [N-1:0]     clr
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign clr[g] = eoi_valid & cfg[g].level & (cfg[g].vec == eoi_vec);
  end
endmodule

// File: rtl/irq_eoi_tracker.sv
module irq_eoi_tracker
  import irq_track_pkg::*;
#(
  parameter int N  = 24,
  parameter int IW = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N-1:0]     irq_pulse,
  input  logic             cfg_we,
  input  logic [IW-1:0]    cfg_idx,
  input  logic [VEC_W-1:0] cfg_vec,
  input  logic             cfg_level,
  input  logic             cfg_mask,
  input  logic             eoi_valid,
  input  logic [VEC_W-1:0] eoi_vec,
  output logic             dlv_valid,
  input  logic             dlv_ready,
  output logic [IW-1:0]    dlv_pin,
  output logic [VEC_W-1:0] dlv_vec,
  output logic             dlv_level,
  output logic [N-1:0]     rirr_o,
  output logic [N-1:0]     dstat_o
);
  pin_cfg_t     cfg_q [N];
  logic [N-1:0] rirr_q, dstat_q;
  logic [N-1:0] elig, grant, eoi_clr, hs_sel, level_v;
  logic         found, hs;
  logic [IW-1:0] pick_idx;

  assign hs = dlv_valid & dlv_ready;

  for (genvar g = 0; g < N; g++) begin : g_pin
    assign level_v[g] = cfg_q[g].level;
    assign elig[g]    = dstat_q[g] & ~cfg_q[g].mask & ~(cfg_q[g].level & rirr_q[g]);
    assign hs_sel[g]  = hs & (dlv_pin == IW'(g));
  end

  lowest_first_pick #(.N(N), .IW(IW)) i_pick (
    .elig (elig),
    .found(found),
    .idx  (pick_idx),
    .grant(grant)
  );

  eoi_vector_match #(.N(N)) i_eoi (
    .eoi_valid(eoi_valid),
    .eoi_vec  (eoi_vec),
    .cfg      (cfg_q),
    .clr      (eoi_clr)
  );

  // configuration entries
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < N; k++) cfg_q[k] <= '{vec: '0, level: 1'b0, mask: 1'b1};
    end else if (cfg_we && (int'(cfg_idx) < N)) begin
      cfg_q[cfg_idx] <= '{vec: cfg_vec, level: cfg_level, mask: cfg_mask};
    end
  end

  // status bits: clear from end-of-interrupt first, set from handshake second
  always_ff @(posedge clk) begin
    if (rst) begin
      rirr_q  <= '0;
      dstat_q <= '0;
    end else begin
      rirr_q  <= (rirr_q & ~eoi_clr) | (hs_sel & {N{dlv_level}});
      dstat_q <= (dstat_q & ~hs_sel) | irq_pulse;
    end
  end

  // delivery offer register
  always_ff @(posedge clk) begin
    if (rst) begin
      dlv_valid <= 1'b0;
      dlv_pin   <= '0;
      dlv_vec   <= '0;
      dlv_level <= 1'b0;
    end else if (hs) begin
      dlv_valid <= 1'b0;
    end else if (!dlv_valid && found) begin
      dlv_valid <= 1'b1;
      dlv_pin   <= pick_idx;
      dlv_vec   <= cfg_q[pick_idx].vec;
      dlv_level <= cfg_q[pick_idx].level;
    end
  end

  assign rirr_o  = rirr_q;
  assign dstat_o = dstat_q;

  AST_HOLD_OFFER: assert property (@(posedge clk) disable iff (rst)
    dlv_valid && !dlv_ready |=> dlv_valid && $stable(dlv_pin) && $stable(dlv_vec) && $stable(dlv_level)); // R5
  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant)); // R4
  AST_PICK_LOADS: assert property (@(posedge clk) disable iff (rst)
    !dlv_valid && found |=> dlv_valid); // R3
  AST_LEVEL_SETS_RIRR: assert property (@(posedge clk) disable iff (rst)
    hs && dlv_level |=> rirr_o[$past(dlv_pin)]); // R9
  AST_DSTAT_DROPS: assert property (@(posedge clk) disable iff (rst)
    hs && !irq_pulse[dlv_pin] |=> !dstat_o[$past(dlv_pin)]); // R2
  AST_RIRR_ONLY_ON_HS: assert property (@(posedge clk) disable iff (rst)
    !hs |=> (rirr_o & ~$past(rirr_o)) == '0); // R6
endmodule

// File: tb/test_irq_eoi_tracker.sv
`timescale 1ns/1ps
module test_irq_eoi_tracker;
  localparam int N = 24;
  localparam int IW = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] irq_pulse = '0;
  logic cfg_we = 1'b0;
  logic [IW-1:0] cfg_idx = '0;
  logic [7:0] cfg_vec = '0;
  logic cfg_level = 1'b0, cfg_mask = 1'b0;
  logic eoi_valid = 1'b0;
  logic [7:0] eoi_vec = '0;
  logic dlv_valid, dlv_ready = 1'b1, dlv_level;
  logic [IW-1:0] dlv_pin;
  logic [7:0] dlv_vec;
  logic [N-1:0] rirr_o, dstat_o;

  int n_cmp = 0, n_bad = 0;
  logic [12:0] expq [$];

  always #2 clk = ~clk;

  irq_eoi_tracker i_irq_eoi_tracker (
    .clk, .rst, .irq_pulse, .cfg_we, .cfg_idx, .cfg_vec, .cfg_level, .cfg_mask,
    .eoi_valid, .eoi_vec, .dlv_valid, .dlv_ready, .dlv_pin, .dlv_vec, .dlv_level,
    .rirr_o, .dstat_o
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic cfg(int idx, logic [7:0] v, logic lvl, logic m);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = IW'(idx); cfg_vec = v; cfg_level = lvl; cfg_mask = m;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic pulse(logic [N-1:0] p);
    @(negedge clk);
    irq_pulse = p;
    @(negedge clk);
    irq_pulse = '0;
  endtask

  task automatic eoi(logic [7:0] v);
    @(negedge clk);
    eoi_valid = 1'b1; eoi_vec = v;
    @(negedge clk);
    eoi_valid = 1'b0;
  endtask

  task automatic expect_dlv(int pin, logic [7:0] v);
    expq.push_back({5'(pin), v});
  endtask

  // monitor: compares each completed handshake against the scoreboard queue
  always @(negedge clk) begin
    #1;
    if (!rst && dlv_valid && dlv_ready) begin
      if (expq.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R3/R7 unexpected delivery actual=pin %0d expected=none", dlv_pin);
      end else begin
        logic [12:0] e;
        e = expq.pop_front();
        chk("R4 delivery pin/vector", {19'd0, dlv_pin, dlv_vec}, {19'd0, e});
      end
    end
  end

  initial begin
    #(200000 * 4);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    tick(3);
    rst = 1'b0;
    tick(1);
    // R1 reset state
    chk("R1 dlv_valid", {31'd0, dlv_valid}, 32'd0);
    chk("R1 rirr", {8'd0, rirr_o}, 32'd0);
    chk("R1 dstat", {8'd0, dstat_o}, 32'd0);
    // R1/R3 reset entries masked: a request is not delivered
    pulse(24'h1 << 4);
    tick(6);
    chk("R1 masked after reset dstat", {31'd0, dstat_o[4]}, 32'd1);

    // R10 configuration
    cfg(4, 8'h44, 1'b0, 1'b1);
    cfg(3, 8'h33, 1'b0, 1'b0);
    cfg(5, 8'h40, 1'b1, 1'b0);
    cfg(7, 8'h40, 1'b1, 1'b0);
    cfg(2, 8'h22, 1'b0, 1'b1);
    chk("R10 config write leaves status", {8'd0, dstat_o}, 32'h10);

    // R4/R5 three simultaneous requests under back-pressure
    dlv_ready = 1'b0;
    pulse((24'h1 << 7) | (24'h1 << 3) | (24'h1 << 5));
    chk("R2 dstat set", {8'd0, dstat_o}, 32'hB8);
    tick(4);
    chk("R5 offer held valid", {31'd0, dlv_valid}, 32'd1);
    chk("R4 lowest pin offered", {27'd0, dlv_pin}, 32'd3);
    chk("R5 offer vector", {24'd0, dlv_vec}, 32'h33);
    expect_dlv(3, 8'h33); expect_dlv(5, 8'h40); expect_dlv(7, 8'h40);
    dlv_ready = 1'b1;
    tick(10);
    chk("R6 rirr set on level only", {8'd0, rirr_o}, 32'hA0);
    chk("R2 dstat cleared", {8'd0, dstat_o}, 32'h10);

    // R3 masked pin keeps pending
    pulse(24'h1 << 2);
    tick(8);
    chk("R3 masked pending", {31'd0, dstat_o[2]}, 32'd1);

    // R7 level pin with rirr set is not re-delivered
    pulse(24'h1 << 5);
    tick(8);
    chk("R7 blocked pending", {31'd0, dstat_o[5]}, 32'd1);
    chk("R7 no offer", {31'd0, dlv_valid}, 32'd0);

    // pin 9 level, delivered, then switched to edge with rirr still 1
    cfg(9, 8'h40, 1'b1, 1'b0);
    expect_dlv(9, 8'h40);
    pulse(24'h1 << 9);
    tick(6);
    cfg(9, 8'h40, 1'b0, 1'b0);
    chk("R6 pin9 rirr", {31'd0, rirr_o[9]}, 32'd1);

    // R8 end-of-interrupt: level 5,7 cleared, edge 9 kept, pin 5 released
    expect_dlv(5, 8'h40);
    eoi(8'h40);
    tick(8);
    chk("R8 rirr after eoi", {8'd0, rirr_o}, 32'h220);
    eoi(8'h41);
    tick(2);
    chk("R8 unmatched vector", {8'd0, rirr_o}, 32'h220);

    // R3 unmask pin 2 releases it
    expect_dlv(2, 8'h22);
    cfg(2, 8'h22, 1'b0, 1'b0);
    tick(6);
    chk("R3 delivered after unmask", {31'd0, dstat_o[2]}, 32'd0);

    // R9 end-of-interrupt and handshake on pin 5 in the same cycle
    eoi(8'h40);
    tick(1);
    chk("R8 pin5 cleared", {31'd0, rirr_o[5]}, 32'd0);
    dlv_ready = 1'b0;
    pulse(24'h1 << 5);
    tick(3);
    chk("R9 pin5 offered", {26'd0, dlv_valid, dlv_pin}, 32'h25);
    expect_dlv(5, 8'h40);
    @(negedge clk);
    dlv_ready = 1'b1; eoi_valid = 1'b1; eoi_vec = 8'h40;
    @(negedge clk);
    dlv_ready = 1'b0; eoi_valid = 1'b0;
    tick(1);
    chk("R9 rirr ends set", {31'd0, rirr_o[5]}, 32'd1);
    chk("R8 edge pin9 kept", {31'd0, rirr_o[9]}, 32'd1);
    dlv_ready = 1'b1;
    tick(6);
    chk("R4 scoreboard drained", expq.size(), 32'd0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule